// File: doc/BRIEF.md
# Probabilistic Neighbour-Row Refresh Injector

This block sits next to a DRAM command scheduler and watches row-close (precharge) events. On each close it draws a pseudo-random number and compares it with a programmable threshold. If the number is below the threshold, the block queues one extra activation of a row that sits directly next to the row just closed. That activation recharges the potential victim row of a repeatedly opened aggressor. The block keeps no counters and no per-row tables. Each close is judged on its own, so the protection depends only on the chosen probability. Raising the threshold raises the firing rate and makes the protection stronger. A threshold of 328 gives about 0.005 per close (328/65536).

Randomness comes from a 32-bit maximal-length Fibonacci LFSR. It is loaded from a seed input while reset is held and advances on every clock after that. Requests wait in a small FIFO whose occupancy is tracked by a three-state machine:

- States:
  - `Q_EMPTY`: nothing is queued.
  - `Q_PART`: some entries are queued and there is still room.
  - `Q_FULL`: every slot holds a request.
- Transitions:
  - T_FILL: `Q_EMPTY` to `Q_PART`, on an accepted push.
  - T_TOP: `Q_PART` to `Q_FULL`, on a push with no pop that fills the last slot.
  - T_DRAIN: `Q_PART` to `Q_EMPTY`, on a pop with no push that takes the last entry.
  - T_RELEASE: `Q_FULL` to `Q_PART`, on any pop.

If a request fires while the FIFO is in `Q_FULL`, the request is dropped and a sticky overflow flag is raised.

Top module: `nbr_refresh_injector`

## Requirements
- R1: A new request is produced only in a cycle where `close_valid` is 1. Cycles without a close never add a request.
- R2: The LFSR state S is updated as S <= {S[30:0], S[31]^S[21]^S[1]^S[0]} on every clock edge after reset. A close fires exactly when S[15:0] < `threshold`, where S is the value held at the clock edge that samples the close. The comparison is unsigned.
- R3: A fired request carries the bank of the close. Its row is close_row+1 when S[31] is 1 and close_row-1 when S[31] is 0.
- R4: At row 0 the request row is always 1. At row 2^ROW_W-1 the request row is always 2^ROW_W-2. Both rules apply whatever the value of S[31].
- R5: When `threshold` is 0, no close ever produces a request.
- R6: Requests wait in a FIFO of DEPTH entries (default 4) and leave in firing order. `req_valid` is 1 exactly when the FIFO is not empty. The head entry stays stable until `req_valid && req_ready` pops it on a clock edge.
- R7: A request that fires while DEPTH entries are held is discarded. It sets `overflow`, which stays 1 until reset. A pop in the same cycle does not make room for that request.
- R8: While `rst_n` is 0, S is loaded from `seed`. A zero seed is replaced by 32'h1ACE_B00C, so S is never zero.
- R9: After reset, `req_valid` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; seed load while low |
| seed | input | 32 | LFSR seed, sampled during reset |
| threshold | input | 16 | Firing threshold; probability is threshold/65536 |
| close_valid | input | 1 | A row close happens this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Row index that was closed |
| req_valid | output | 1 | An extra activate is pending |
| req_ready | input | 1 | Scheduler accepts the pending activate |
| req_bank | output | BANK_W | Bank of the requested activate |
| req_row | output | ROW_W | Neighbour row to activate |
| overflow | output | 1 | Sticky: a request was dropped on a full queue |

## Verification
The assertions check the following on every cycle:
- A queue level rise always follows a close.
- Any fired row is one step away from the closed row, and the edge rows go inward.
- A zero threshold never raises the level.
- The LFSR never reaches zero.
- The queue stays within its depth, and its state agrees with its level.
- The head is held while it is stalled.
- The overflow flag never clears.

The bench's scenarios show the rest:
- The exact firing decisions and directions, which follow from the LFSR sequence.
- FIFO ordering under changing ready patterns.
- The drop-on-full behaviour when a pop happens in the same cycle.
- The substitution for a zero seed.

// File: rtl/nri_pkg.sv
package nri_pkg;
    localparam int           RND_W         = 32;
    localparam int           CMP_W         = 16;
    localparam logic [31:0]  RND_TAPS      = 32'h8020_0003;
    localparam logic [31:0]  SEED_FALLBACK = 32'h1ACE_B00C;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/nri_lfsr.sv
module nri_lfsr
    import nri_pkg::*;
#(
    parameter int          W        = RND_W,
    parameter int          SLICE_W  = CMP_W,
    parameter logic [W-1:0] TAPS    = RND_TAPS,
    parameter logic [W-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       seed,
    output logic [SLICE_W-1:0] rnd_slice,
    output logic               rnd_dir
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (seed == '0) ? FALLBACK : seed;
        end else begin
            state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
        end
    end

    always_comb begin
        rnd_slice = state_q[SLICE_W-1:0];
        rnd_dir   = state_q[W-1];
    end

    // R8: the generator never falls into the all-zero lock-up state
    a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/nri_pick.sv
module nri_pick #(
    parameter int ROW_W = 10,
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_valid,
    input  logic [ROW_W-1:0] close_row,
    input  logic [CMP_W-1:0] rnd_slice,
    input  logic             rnd_dir,
    input  logic [CMP_W-1:0] threshold,
    output logic             fire,
    output logic [ROW_W-1:0] tgt_row
);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
    localparam logic [ROW_W-1:0] ROW_TOP = '1;

    logic hit;

    always_comb begin
        hit  = rnd_slice < threshold;
        fire = close_valid && hit;
        if (close_row == '0) begin
            tgt_row = ROW_ONE;
        end else if (close_row == ROW_TOP) begin
            tgt_row = ROW_TOP - ROW_ONE;
        end else if (rnd_dir) begin
            tgt_row = close_row + ROW_ONE;
        end else begin
            tgt_row = close_row - ROW_ONE;
        end
    end

    // R3: a fired target is always one row away from the closed row
    a_r3_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((tgt_row == close_row + ROW_ONE) || (tgt_row + ROW_ONE == close_row)));
    // R4: edge rows always turn inward
    a_r4_bottom_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && close_row == '0) |-> (tgt_row == ROW_ONE));
    a_r4_top_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && close_row == ROW_TOP) |-> (tgt_row == ROW_TOP - ROW_ONE));
    // R1: firing needs a close in the same cycle
    a_r1_fire_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        !close_valid |-> !fire);
endmodule

// File: rtl/nri_fifo.sv
module nri_fifo
    import nri_pkg::*;
#(
    parameter int DW    = 13,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [DW-1:0]             push_data,
    input  logic                      pop_ready,
    output logic                      out_valid,
    output logic [DW-1:0]             out_data,
    output logic                      overflow,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    q_state_e           st_q, st_d;
    logic [DW-1:0]      mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   cnt_q;
    logic               accept, take, ovf_q;

    assign accept = push && (st_q != Q_FULL);
    assign take   = (st_q != Q_EMPTY) && pop_ready;

    // next-state: named transitions T_FILL, T_TOP, T_DRAIN, T_RELEASE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: if (accept) st_d = Q_PART;
            Q_PART: begin
                if (accept && !take && cnt_q == CNT_FULL - CNT_ONE) st_d = Q_FULL;
                else if (take && !accept && cnt_q == CNT_ONE)       st_d = Q_EMPTY;
            end
            Q_FULL:  if (take) st_d = Q_PART;
            default: st_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= Q_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PTR_W'(1);
            if (take)   rd_ptr <= rd_ptr + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(take);
            if (push && st_q == Q_FULL) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // outputs
    always_comb begin
        out_valid = (st_q != Q_EMPTY);
        out_data  = mem[rd_ptr];
        overflow  = ovf_q;
        level     = cnt_q;
    end

    // R6: level never exceeds depth; state agrees with level
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
    a_r6_state_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == Q_EMPTY) == (cnt_q == '0)) && ((st_q == Q_FULL) == (cnt_q == CNT_FULL)));
    // R6: a stalled head holds
    a_r6_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/nbr_refresh_injector.sv
module nbr_refresh_injector
    import nri_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 10,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RND_W-1:0]  seed,
    input  logic [CMP_W-1:0]  threshold,
    input  logic              close_valid,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [ROW_W-1:0]  close_row,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [BANK_W-1:0] req_bank,
    output logic [ROW_W-1:0]  req_row,
    output logic              overflow
);
    localparam int DW    = BANK_W + ROW_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CMP_W-1:0] rnd_slice;
    logic             rnd_dir, fire;
    logic [ROW_W-1:0] tgt_row;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] level;

    nri_lfsr #(.W(RND_W), .SLICE_W(CMP_W)) u_rng (
        .clk(clk), .rst_n(rst_n), .seed(seed),
        .rnd_slice(rnd_slice), .rnd_dir(rnd_dir)
    );

    nri_pick #(.ROW_W(ROW_W), .CMP_W(CMP_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .close_valid(close_valid), .close_row(close_row),
        .rnd_slice(rnd_slice), .rnd_dir(rnd_dir), .threshold(threshold),
        .fire(fire), .tgt_row(tgt_row)
    );

    nri_fifo #(.DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(fire), .push_data({close_bank, tgt_row}),
        .pop_ready(req_ready), .out_valid(req_valid), .out_data(head),
        .overflow(overflow), .level(level)
    );

    assign {req_bank, req_row} = head;

    // R1: queue level only rises after a close
    a_r1_push_needs_close: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> $past(close_valid));
    // R5: zero threshold never grows the queue
    a_r5_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold == '0) |=> !(level > $past(level)));
endmodule

// File: tb/nbr_refresh_injector_tb_top.sv
module nbr_refresh_injector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 10;
    localparam int DEPTH  = 4;
    localparam int ROW_MAX = (1 << ROW_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       seed = 32'h1234_5678;
    logic [15:0]       threshold = '0;
    logic              close_valid = 1'b0;
    logic [BANK_W-1:0] close_bank = '0;
    logic [ROW_W-1:0]  close_row = '0;
    logic              req_valid, req_ready = 1'b0;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic              overflow;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0, ovf_exp = 0;
    logic [31:0] m;
    logic [BANK_W+ROW_W-1:0] q[$];

    nbr_refresh_injector #(.BANK_W(BANK_W), .ROW_W(ROW_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .seed(seed), .threshold(threshold),
        .close_valid(close_valid), .close_bank(close_bank), .close_row(close_row),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // R2 R8: independent generator model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m <= (seed == 32'd0) ? 32'h1ACE_B00C : seed;
        else        m <= step(m);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle, called at a negedge: check outputs, drive inputs, update model
    task automatic cycle(input bit cv, input int b, input int r, input bit rdy, input string tag);
        bit exp_v;
        int want_row;
        exp_v = (q.size() != 0);
        check(req_valid == exp_v, {tag, " R6 req_valid"}, int'(req_valid), int'(exp_v));
        if (req_valid && exp_v)
            check({req_bank, req_row} == q[0], {tag, " R3 R6 head"},
                  int'({req_bank, req_row}), int'(q[0]));
        check(overflow == ovf_exp, {tag, " R7 overflow"}, int'(overflow), int'(ovf_exp));
        close_valid = cv;
        close_bank  = BANK_W'(b);
        close_row   = ROW_W'(r);
        req_ready   = rdy;
        if (cv && (m[15:0] < threshold)) begin
            if (r == 0)            want_row = 1;
            else if (r == ROW_MAX) want_row = ROW_MAX - 1;
            else if (m[31])        want_row = r + 1;
            else                   want_row = r - 1;
            if (q.size() == DEPTH) ovf_exp = 1;
            else q.push_back({BANK_W'(b), ROW_W'(want_row)});
        end
        if (req_valid && rdy && q.size() != 0) void'(q.pop_front());
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] s);
        close_valid = 0; req_ready = 0;
        seed = s; rst_n = 0;
        q.delete(); ovf_exp = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(req_valid == 1'b0, "R9 req_valid in reset", int'(req_valid), 0);
        check(overflow == 1'b0, "R9 overflow in reset", int'(overflow), 0);
        rst_n = 1;
        @(negedge clk);
        check(req_valid == 1'b0, "R9 req_valid after reset", int'(req_valid), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset(32'h1234_5678);

        // R2 R3 R4: full row sweep, always fire, every bank
        threshold = 16'hFFFF;
        for (int r = 0; r <= ROW_MAX; r++) cycle(1, r % 8, r, 1, "R2 R3 R4 sweep");
        for (int i = 0; i < 8; i++) cycle(0, 0, 0, 1, "R1 drain");

        // R5: zero threshold
        threshold = 16'd0;
        for (int i = 0; i < 500; i++) begin
            cycle(1, i % 8, (i % 3 == 0) ? 0 : ((i % 3 == 1) ? ROW_MAX : i), i % 2, "R5 zero");
            check(req_valid == 1'b0, "R5 no request", int'(req_valid), 0);
        end

        // R1 R2 R6: threshold sweep, gaps in closes, uneven ready
        for (int t = 0; t < 5; t++) begin
            case (t)
                0: threshold = 16'd1;
                1: threshold = 16'd328;
                2: threshold = 16'd4096;
                3: threshold = 16'd32768;
                default: threshold = 16'd65000;
            endcase
            for (int i = 0; i < 1500; i++) begin
                int r;
                r = (i * 37 + t * 11) % (ROW_MAX + 1);
                if (i % 50 == 0)  r = 0;
                if (i % 50 == 25) r = ROW_MAX;
                cycle(i % 5 != 4, (i + t) % 8, r, (i % 3) != 0, "R1 R2 R6 thresh");
            end
        end

        // R7: fill with ready low, then pop while full
        threshold = 16'hFFFF;
        for (int i = 0; i < 12; i++) cycle(1, i % 8, 100 + i, 0, "R7 fill");
        for (int i = 0; i < 4; i++) cycle(1, 2, 500 + i, 1, "R7 pop while full");
        for (int i = 0; i < 10; i++) cycle(0, 0, 0, 1, "R7 drain");
        check(overflow == 1'b1, "R7 sticky after drain", int'(overflow), 1);

        // R8 R9: zero seed substitution
        do_reset(32'd0);
        check(overflow == 1'b0, "R9 overflow cleared", int'(overflow), 0);
        threshold = 16'd20000;
        for (int i = 0; i < 300; i++)
            cycle(1, i % 8, (i % 4 == 0) ? 0 : ((i % 4 == 1) ? ROW_MAX : i * 3), i % 4 != 3, "R8 zero seed");
        for (int i = 0; i < 8; i++) cycle(0, 0, 0, 1, "R8 drain");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule